// File: doc/BRIEF.md
# Two-Wire Bus Unjam Sequencer

This block frees a two-wire serial bus that a peripheral has left stuck. It usually happens after a transfer is cut off midway and the peripheral is still shifting out a byte. The block owns the clock and data lines through open-drain controls, so a line is either pulled low or let go. A one-cycle `start` request runs a fixed, bounded sequence:

1. Let both lines go.
2. Poll the clock line at a coarse interval until a stretching peripheral releases it, giving up after a timeout.
3. Clock the bus, one pulse at a time, until the data line is released, for no more than one byte plus the acknowledge slot.
4. Finish with a START condition and then a STOP condition, which reset every peripheral's bus logic.

All delays are given in microseconds and turned into system clock cycles from a clock-frequency parameter. A bench can therefore run a scaled-down timebase. Status is a busy level, a single-cycle completion pulse, and an error flag that stays set until the next run begins.

Top module: `twi_unjam`

## Requirements
- R1: After reset both pulls are off (lines released), `busy`, `done` and `bus_err` are 0.
- R2: A `start` sampled while `busy` is 0 sets `busy` and clears `bus_err` on the next cycle. A `start` sampled while `busy` is 1 is ignored and does not alter the sequence in progress.
- R3: The block never pulls a line low while idle or while polling the clock line. It has no way to drive a line high.
- R4: While the synchronised clock line reads low, it is re-checked every POLL_US. After TIMEOUT_US/POLL_US checks all read low, the run ends with `bus_err` set and no clock pulse issued.
- R5: If the data line reads high once the clock line is free, no clock pulse is issued.
- R6: Each recovery pulse pulls the clock low for exactly HALF_US worth of cycles. The clock is then released for HALF_US plus one cycle before the data line is sampled and any next pulse begins.
- R7: If the data line is still low after MAX_PULSES pulses (9 by default), the run ends with `bus_err` set, and no START or STOP is issued.
- R8: On success, the data line is pulled low while the clock line is released (START) for exactly HALF_US worth of cycles. It is then released while the clock is high (STOP), and `done` follows HALF_US later.
- R9: Every run ends with exactly one single-cycle `done` pulse. `bus_err` stays set after a failed run until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the recovery sequence |
| scl_in | input | 1 | Clock line as read from the pad (asynchronous) |
| sda_in | input | 1 | Data line as read from the pad (asynchronous) |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of every run |
| bus_err | output | 1 | Last run failed (stretch timeout or data stuck) |

## Verification
The completion of one run can coincide with a new request, because `done` rises in the same cycle that `busy` falls. The bench ends a failing run (data held through all nine pulses) and drives `start` in the very cycle `done` is seen. It expects `busy` to be set on the next cycle with `bus_err` already cleared. The second run then has to finish cleanly, with the pulse, START, STOP and done counts summed over both runs matching the model of the stuck peripheral.

// File: rtl/twi_unjam_pkg.sv
package twi_unjam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCL_CHK,
    ST_SCL_WAIT,
    ST_SDA_CHK,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_START,
    ST_STOP
  } unjam_state_e;

  function automatic int unsigned us_to_cyc(input int unsigned hz, input int unsigned us);
    longint unsigned prod;
    prod = longint'(hz) * longint'(us);
    return int'(prod / 64'd1000000);
  endfunction

endpackage

// File: rtl/twi_unjam_sync.sv
module twi_unjam_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/twi_unjam_timer.sv
module twi_unjam_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/twi_unjam.sv
module twi_unjam
  import twi_unjam_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned POLL_US    = 500,
  parameter int unsigned TIMEOUT_US = 40_000,
  parameter int unsigned HALF_US    = 5,
  parameter int unsigned MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done,
  output logic bus_err
);
  localparam int unsigned POLL_CYC = us_to_cyc(CLK_HZ, POLL_US);
  localparam int unsigned HALF_CYC = us_to_cyc(CLK_HZ, HALF_US);
  localparam int unsigned NPOLL    = TIMEOUT_US / POLL_US;
  localparam int unsigned MAXCYC   = (POLL_CYC > HALF_CYC) ? POLL_CYC : HALF_CYC;
  localparam int unsigned TW       = $clog2(MAXCYC + 1) + 1;
  localparam int unsigned NW       = $clog2(NPOLL + 1) + 1;
  localparam int unsigned PW       = $clog2(MAX_PULSES + 1) + 1;
  localparam logic [TW-1:0] POLL_LD = TW'(POLL_CYC - 1);
  localparam logic [TW-1:0] HALF_LD = TW'(HALF_CYC - 1);

  unjam_state_e  state;
  logic [NW-1:0] polls;
  logic [PW-1:0] pulses;
  logic [1:0]    line_s;
  logic          scl_s, sda_s;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;

  twi_unjam_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  twi_unjam_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
  );

  // Timer reload decisions: one per delay-state entry.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = HALF_LD;
    unique case (state)
      ST_SCL_CHK: if (!scl_s) begin tmr_load = 1'b1; tmr_val = POLL_LD; end
      ST_SDA_CHK: tmr_load = sda_s || (pulses != PW'(MAX_PULSES));
      ST_CLK_LO:  tmr_load = tmr_exp;
      ST_START:   tmr_load = tmr_exp;
      default:    tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      polls    <= '0;
      pulses   <= '0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      bus_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          scl_pull <= 1'b0;
          sda_pull <= 1'b0;
          if (start) begin
            busy    <= 1'b1;
            bus_err <= 1'b0;
            polls   <= '0;
            pulses  <= '0;
            state   <= ST_SCL_CHK;
          end
        end
        ST_SCL_CHK: state <= scl_s ? ST_SDA_CHK : ST_SCL_WAIT;
        ST_SCL_WAIT: if (tmr_exp) begin
          if (polls == NW'(NPOLL - 1)) begin
            state <= ST_IDLE; busy <= 1'b0; done <= 1'b1; bus_err <= 1'b1;
          end else begin
            polls <= polls + 1'b1;
            state <= ST_SCL_CHK;
          end
        end
        ST_SDA_CHK: begin
          if (sda_s) begin
            sda_pull <= 1'b1;
            state    <= ST_START;
          end else if (pulses == PW'(MAX_PULSES)) begin
            state <= ST_IDLE; busy <= 1'b0; done <= 1'b1; bus_err <= 1'b1;
          end else begin
            scl_pull <= 1'b1;
            state    <= ST_CLK_LO;
          end
        end
        ST_CLK_LO: if (tmr_exp) begin
          scl_pull <= 1'b0;
          state    <= ST_CLK_HI;
        end
        ST_CLK_HI: if (tmr_exp) begin
          pulses <= pulses + 1'b1;
          state  <= ST_SDA_CHK;
        end
        ST_START: if (tmr_exp) begin
          sda_pull <= 1'b0;
          state    <= ST_STOP;
        end
        ST_STOP: if (tmr_exp) begin
          state <= ST_IDLE; busy <= 1'b0; done <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twi_unjam_chk.sv
module twi_unjam_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic scl_pull,
  input logic sda_pull,
  input logic busy,
  input logic done,
  input logic bus_err
);
  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_pull && !sda_pull));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !bus_err));

  // R8
  start_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_pull);

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(scl_pull && sda_pull));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_err) |-> (done && !busy));
endmodule

bind twi_unjam twi_unjam_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .busy(busy), .done(done), .bus_err(bus_err)
);

// File: tb/twi_unjam_test.sv
module twi_unjam_test;
  localparam int HZ    = 1_000_000;
  localparam int POLL  = 50;
  localparam int TMO   = 400;
  localparam int HALF  = 5;
  localparam int MAXP  = 9;
  localparam int NPOLL = TMO / POLL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic stretch = 1'b0;
  logic arm = 1'b0;
  logic hold;
  int   stuck_k = 0;
  logic scl_pull, sda_pull, busy, done, bus_err;
  logic scl_line, sda_line;

  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  assign scl_line = !scl_pull && !stretch;
  assign sda_line = !sda_pull && !hold;

  twi_unjam #(.CLK_HZ(HZ), .POLL_US(POLL), .TIMEOUT_US(TMO), .HALF_US(HALF),
              .MAX_PULSES(MAXP)) uut (
    .clk(clk), .rst(rst), .start(start), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done), .bus_err(bus_err)
  );

  // Stuck peripheral: holds data low until it has seen stuck_k clock rises.
  int   rises;
  logic scl_q;
  always @(posedge clk) begin
    scl_q <= scl_line;
    if (arm) begin
      rises <= 0;
      hold  <= (stuck_k > 0);
    end else if (scl_line && !scl_q) begin
      rises <= rises + 1;
      if (rises + 1 >= stuck_k) hold <= 1'b0;
    end
  end

  // Port monitors
  int n_pulse, n_start, n_stop, n_done, n_wbad, hi_cnt, gap_cnt, sd_cnt;
  logic p_scl, p_sda, seen_fall;
  always @(posedge clk) begin
    p_scl <= scl_pull;
    p_sda <= sda_pull;
    if (arm) begin
      n_pulse <= 0; n_start <= 0; n_stop <= 0; n_done <= 0; n_wbad <= 0;
      hi_cnt <= 0; gap_cnt <= 0; sd_cnt <= 0; seen_fall <= 1'b0;
    end else begin
      if (done) n_done <= n_done + 1;
      if (scl_pull && !p_scl) begin
        n_pulse <= n_pulse + 1;
        hi_cnt  <= 1;
        if (seen_fall && gap_cnt != HALF + 1) n_wbad <= n_wbad + 1;
      end else if (scl_pull) hi_cnt <= hi_cnt + 1;
      if (!scl_pull && p_scl) begin
        seen_fall <= 1'b1;
        gap_cnt   <= 1;
        if (hi_cnt != HALF) n_wbad <= n_wbad + 1;
      end else if (!scl_pull) gap_cnt <= gap_cnt + 1;
      if (sda_pull && !p_sda) begin
        sd_cnt <= 1;
        if (scl_line) n_start <= n_start + 1;
      end else if (sda_pull) sd_cnt <= sd_cnt + 1;
      if (!sda_pull && p_sda) begin
        if (scl_line) n_stop <= n_stop + 1;
        if (sd_cnt != HALF) n_wbad <= n_wbad + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm_model(input int k, input bit str);
    @(negedge clk);
    stuck_k = k;
    stretch = str;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input int k, input int len, input bit poke, input bit exp_err,
                     input int exp_p, input string tag);
    arm_model(k, len > 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy after start"}, int'(busy), 1);
    chk({tag, " R2 err cleared"}, int'(bus_err), 0);
    fork
      begin
        if (len > 0) begin
          repeat (len - 1) @(negedge clk);
          stretch = 1'b0;
        end
      end
      begin
        if (poke) begin
          repeat (20) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
      begin
        while (!done) @(negedge clk);
      end
    join
    repeat (8) @(negedge clk);
    chk({tag, " R9 single done"}, n_done, 1);
    chk({tag, " R4/R7 error flag"}, int'(bus_err), int'(exp_err));
    chk({tag, " R5/R6/R7 pulse count"}, n_pulse, exp_p);
    chk({tag, " R6/R8 widths"}, n_wbad, 0);
    chk({tag, " R8 start count"}, n_start, exp_err ? 0 : 1);
    chk({tag, " R8 stop count"}, n_stop, exp_err ? 0 : 1);
    chk({tag, " R3 idle released"}, int'(scl_pull || sda_pull), 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl_pull", int'(scl_pull), 0);
    chk("R1 sda_pull", int'(sda_pull), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 bus_err", int'(bus_err), 0);

    // Stuck data sweep: R5 (k=0), R6 pulses, R7 give-up after MAXP
    for (int k = 0; k <= MAXP + 2; k++) begin
      run(k, 0, 1'b0, k > MAXP, (k < MAXP) ? k : MAXP, $sformatf("stuck%0d", k));
      if (k > MAXP) begin
        repeat (20) @(negedge clk);
        chk("R9 err sticky", int'(bus_err), 1);
      end
    end

    // Clock stretch sweep: R4 timeout after NPOLL checks
    for (int s = 0; s <= NPOLL + 1; s++) begin
      run(0, s * POLL + POLL / 2, 1'b0, s >= NPOLL - 1, 0, $sformatf("stretch%0d", s));
    end

    // R2: start while busy is ignored
    run(3, 0, 1'b1, 1'b0, 3, "poke");

    // Done and new start in the same cycle
    arm_model(MAXP + 2, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R7 err at done", int'(bus_err), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 back-to-back busy", int'(busy), 1);
    chk("R2 back-to-back err cleared", int'(bus_err), 0);
    while (!done) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R9 two dones", n_done, 2);
    chk("R6 total pulses", n_pulse, MAXP + 2);
    chk("R8 one start", n_start, 1);
    chk("R8 one stop", n_stop, 1);
    chk("R9 second run ok", int'(bus_err), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule